// File: doc/BRIEF.md
# Broadcast-Weight Vector Multiply-Accumulate Cluster

This block is the arithmetic core of a neural-network inference engine. Sixteen lanes work side by side. On every accepted beat each lane forms the signed dot product of one weight vector and its own 8-element activation vector, using a registered adder tree. It then folds that product into a private 32-bit running sum. The weight vector arrives once on a wide bus and is fanned out to all lanes, so one beat performs 128 multiply-accumulates.

A controller upstream presents a weight vector with the valid flag and one activation vector for each lane. On the first beat of a new output neuron it raises the clear flag, and it raises the hold flag to drop a beat it cannot use. Each lane's running sum appears on its own 32-bit slice of the output bus. An output-valid pulse marks every cycle in which the sums were just updated. Address generation, activation storage and quantization of the sums belong to neighbouring blocks.

Top module: `vmac_cluster`

## Requirements
- R1: A synchronous active-high reset sets all sixteen sums to zero and drives `sum_valid` low on the cycle after the reset edge.
- R2: Each lane computes the signed dot product of 8 signed 8-bit pairs. Weight element i is `wt_vec[8i+7:8i]`. Activation element i of lane p is `act_vec[(8p+i)*8 +: 8]`. The sum of lane p is `acc_out[32p +: 32]`.
- R3: The one weight vector is applied to all 16 lanes in the same beat. Lanes given different activations produce different, independently correct sums.
- R4: An accepted beat with `acc_clear` high replaces the lane's sum with that beat's dot product.
- R5: An accepted beat with `acc_clear` low adds that beat's dot product to the lane's previous sum.
- R6: A beat is accepted when `wt_valid` is high and `acc_hold` is low. Its effect on `acc_out`, together with a one-cycle high on `sum_valid`, is visible after the second rising edge following the edge that samples it.
- R7: A beat with `acc_hold` high is discarded, including its clear flag. The sums keep their values and `sum_valid` stays low for that beat.
- R8: When `wt_valid` is low, `acc_clear` has no effect, the sums keep their values and `sum_valid` stays low.
- R9: A sum wraps in two's complement at 32 bits with no saturation. Adding 131072 to 2147352576 yields -2147483648.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_valid | input | 1 | Qualifies the weight vector and activations of this beat |
| wt_vec | input | 64 | Shared weight vector, 8 signed bytes |
| act_vec | input | 1024 | Sixteen activation vectors of 8 signed bytes each |
| acc_clear | input | 1 | Start a new sum with this beat |
| acc_hold | input | 1 | Discard this beat |
| acc_out | output | 512 | Sixteen 32-bit running sums |
| sum_valid | output | 1 | Sums were updated by an accepted beat |

## Verification
A fault in a lane's adder tree or running-sum register shows up on that lane's slice of `acc_out` two edges after the beat that exposes it. The fault then stays visible, because later beats add on top of the corrupted value until a clear flushes it. A slip in the control pipeline shows up instead as `sum_valid` pulsing one cycle early or late. It can also show up as a held or idle beat that still changes the sums. Both kinds of fault are therefore caught within two cycles of the stimulus that triggers them.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

    localparam int NUM_PE  = 16;
    localparam int VEC_LEN = 8;
    localparam int DATA_W  = 8;
    localparam int ACC_W   = 32;

    // Control word carried through the tree stage alongside the products
    typedef struct packed {
        logic take;   // beat accepted
        logic fresh;  // beat starts a new sum
    } beat_ctl_t;

    function automatic beat_ctl_t decode_beat(input logic valid, input logic clear,
                                              input logic hold);
        beat_ctl_t c;
        c.take  = valid & ~hold;
        c.fresh = valid & ~hold & clear;
        return c;
    endfunction

endpackage

// File: rtl/vmac_dot.sv
module vmac_dot #(
    parameter int VEC_LEN = vmac_pkg::VEC_LEN,
    parameter int DATA_W  = vmac_pkg::DATA_W,
    parameter int SUM_W   = 2 * DATA_W + $clog2(VEC_LEN)
) (
    input  logic                          clk,
    input  logic [VEC_LEN*DATA_W-1:0]     wt,
    input  logic [VEC_LEN*DATA_W-1:0]     act,
    output logic signed [SUM_W-1:0]       dot_q
);
    localparam int PROD_W = 2 * DATA_W;

    // Heap-ordered tree: leaves at [VEC_LEN .. 2*VEC_LEN-1], root at 1
    logic signed [SUM_W-1:0] node [1:2*VEC_LEN-1];

    for (genvar i = 0; i < VEC_LEN; i++) begin : g_leaf
        logic signed [PROD_W-1:0] prod;
        assign prod = $signed(wt[i*DATA_W +: DATA_W]) * $signed(act[i*DATA_W +: DATA_W]);
        assign node[VEC_LEN+i] = SUM_W'(prod);
    end

    for (genvar k = 1; k < VEC_LEN; k++) begin : g_add
        assign node[k] = node[2*k] + node[2*k+1];
    end

    always_ff @(posedge clk) begin
        dot_q <= node[1];
    end

endmodule

// File: rtl/vmac_lane.sv
module vmac_lane #(
    parameter int VEC_LEN = vmac_pkg::VEC_LEN,
    parameter int DATA_W  = vmac_pkg::DATA_W,
    parameter int ACC_W   = vmac_pkg::ACC_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  vmac_pkg::beat_ctl_t           stg_ctl,
    input  logic [VEC_LEN*DATA_W-1:0]     wt,
    input  logic [VEC_LEN*DATA_W-1:0]     act,
    output logic signed [ACC_W-1:0]       acc_q
);
    localparam int SUM_W = 2 * DATA_W + $clog2(VEC_LEN);

    logic signed [SUM_W-1:0] dot_q;
    logic signed [ACC_W-1:0] dot_ext;

    vmac_dot #(.VEC_LEN(VEC_LEN), .DATA_W(DATA_W), .SUM_W(SUM_W)) u_dot (
        .clk  (clk),
        .wt   (wt),
        .act  (act),
        .dot_q(dot_q)
    );

    assign dot_ext = ACC_W'(dot_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (stg_ctl.take) begin
            acc_q <= stg_ctl.fresh ? dot_ext : acc_q + dot_ext;
        end
    end

    // R4: a fresh beat leaves exactly its own product
    a_r4_clear_loads: assert property (@(posedge clk) disable iff (rst)
        (stg_ctl.take && stg_ctl.fresh) |=> (acc_q == ACC_W'($past(dot_q))));

    // R5 / R9: an accumulating beat adds with 32-bit wrap
    a_r5_adds_wrapped: assert property (@(posedge clk) disable iff (rst)
        (stg_ctl.take && !stg_ctl.fresh) |=>
            (acc_q == ACC_W'($past(acc_q) + ACC_W'($past(dot_q)))));

    // R7 / R8: no accepted beat, no change
    a_r7_idle_keeps: assert property (@(posedge clk) disable iff (rst)
        !stg_ctl.take |=> $stable(acc_q));

endmodule

// File: rtl/vmac_cluster.sv
module vmac_cluster #(
    parameter int NUM_PE  = vmac_pkg::NUM_PE,
    parameter int VEC_LEN = vmac_pkg::VEC_LEN,
    parameter int DATA_W  = vmac_pkg::DATA_W,
    parameter int ACC_W   = vmac_pkg::ACC_W
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wt_valid,
    input  logic [VEC_LEN*DATA_W-1:0]            wt_vec,
    input  logic [NUM_PE*VEC_LEN*DATA_W-1:0]     act_vec,
    input  logic                                 acc_clear,
    input  logic                                 acc_hold,
    output logic [NUM_PE*ACC_W-1:0]              acc_out,
    output logic                                 sum_valid
);
    import vmac_pkg::*;

    localparam int VEC_W = VEC_LEN * DATA_W;

    beat_ctl_t stg_ctl;

    // Control rides with the registered adder tree
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_ctl   <= '0;
            sum_valid <= 1'b0;
        end else begin
            stg_ctl   <= decode_beat(wt_valid, acc_clear, acc_hold);
            sum_valid <= stg_ctl.take;
        end
    end

    for (genvar p = 0; p < NUM_PE; p++) begin : g_lane
        logic signed [ACC_W-1:0] lane_acc;

        vmac_lane #(.VEC_LEN(VEC_LEN), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .stg_ctl(stg_ctl),
            .wt     (wt_vec),
            .act    (act_vec[p*VEC_W +: VEC_W]),
            .acc_q  (lane_acc)
        );

        assign acc_out[p*ACC_W +: ACC_W] = lane_acc;
    end

    // R1: reset clears the valid flag on the next cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !sum_valid);

    // R6: an accepted beat produces a valid pulse two edges later
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (wt_valid && !acc_hold) |=> ##1 sum_valid);

    // R7: a held beat never produces a valid pulse
    a_r7_hold_no_valid: assert property (@(posedge clk) disable iff (rst)
        (acc_hold || !wt_valid) |=> ##1 (!sum_valid || $past(wt_valid && !acc_hold)));

endmodule

// File: tb/vmac_cluster_bench.sv
module vmac_cluster_bench;
    localparam int NP = 16;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          wt_valid;
    logic [63:0]   wt_vec;
    logic [1023:0] act_vec;
    logic          acc_clear;
    logic          acc_hold;
    logic [511:0]  acc_out;
    logic          sum_valid;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    always #10 clk = ~clk;  // 50 MHz

    vmac_cluster u_vmac_cluster (
        .clk(clk), .rst(rst), .wt_valid(wt_valid), .wt_vec(wt_vec),
        .act_vec(act_vec), .acc_clear(acc_clear), .acc_hold(acc_hold),
        .acc_out(acc_out), .sum_valid(sum_valid)
    );

    // Behavioural model: one beat in flight, then the sums
    logic signed [31:0] m_acc [NP];
    logic signed [31:0] s_dot [NP];
    bit s_take, s_fresh, m_vld;

    function automatic int lane_dot(int p);
        int s = 0;
        for (int i = 0; i < NV; i++) begin
            int w = int'($signed(wt_vec[i*8 +: 8]));
            int a = int'($signed(act_vec[(p*NV+i)*8 +: 8]));
            s += w * a;
        end
        return s;
    endfunction

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            for (int p = 0; p < NP; p++) m_acc[p] = 0;
            m_vld = 0; s_take = 0; s_fresh = 0;
        end else begin
            for (int p = 0; p < NP; p++)
                if (s_take) m_acc[p] = s_fresh ? s_dot[p] : m_acc[p] + s_dot[p];
            m_vld   = s_take;
            s_take  = wt_valid && !acc_hold;
            s_fresh = wt_valid && !acc_hold && acc_clear;
            for (int p = 0; p < NP; p++) s_dot[p] = lane_dot(p);
        end
        @(negedge clk);
        checks++;
        if (sum_valid !== m_vld) begin
            errors++;
            $display("FAIL %s sum_valid actual=%0b expected=%0b", tag, sum_valid, m_vld);
        end
        for (int p = 0; p < NP; p++) begin
            if ($signed(acc_out[p*32 +: 32]) !== m_acc[p]) begin
                errors++;
                $display("FAIL %s lane %0d actual=%0d expected=%0d", tag, p,
                         $signed(acc_out[p*32 +: 32]), m_acc[p]);
            end
        end
    endtask

    task automatic beat(bit v, bit c, bit h);
        wt_valid = v; acc_clear = c; acc_hold = h;
        tick();
    endtask

    task automatic rand_data();
        wt_vec = {$urandom, $urandom};
        for (int k = 0; k < 32; k++) act_vec[k*32 +: 32] = $urandom;
    endtask

    initial begin
        rst = 1'b1; wt_valid = 0; acc_clear = 0; acc_hold = 0;
        wt_vec = '0; act_vec = '0;
        for (int p = 0; p < NP; p++) m_acc[p] = 0;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tag = "R1"; beat(0, 0, 0);

        // R2 / R3: distinct lanes, one shared weight vector, fresh sums
        tag = "R3"; rand_data(); beat(1, 1, 0);
        tag = "R2"; rand_data(); beat(1, 1, 0);
        tag = "R6"; beat(0, 0, 0); beat(0, 0, 0);

        // R5: accumulation over several random beats
        tag = "R5";
        for (int n = 0; n < 20; n++) begin rand_data(); beat(1, n == 0, 0); end
        beat(0, 0, 0); beat(0, 0, 0);

        // R7: held beats, including a held clear
        tag = "R7";
        for (int n = 0; n < 6; n++) begin rand_data(); beat(1, n[0], 1); end
        beat(0, 0, 0); beat(0, 0, 0);

        // R8: invalid beats with clear raised
        tag = "R8";
        for (int n = 0; n < 6; n++) begin rand_data(); beat(0, 1, 0); end

        // R4: clear mid-stream restarts the sums
        tag = "R4";
        rand_data(); beat(1, 0, 0);
        rand_data(); beat(1, 1, 0);
        rand_data(); beat(1, 0, 1);
        rand_data(); beat(1, 0, 0);
        beat(0, 0, 0); beat(0, 0, 0);

        // R6: interleaved accepted and empty beats
        tag = "R6";
        for (int n = 0; n < 24; n++) begin rand_data(); beat(n % 3 != 1, n % 7 == 0, n % 5 == 4); end
        beat(0, 0, 0); beat(0, 0, 0);

        // R9: extreme operands, sum climbs past the positive limit and wraps
        tag = "R9";
        wt_vec = {8{8'h80}}; act_vec = {128{8'h80}};
        beat(1, 1, 0);
        for (int n = 0; n < 16390; n++) beat(1, 0, 0);
        wt_vec = {8{8'h7f}}; beat(1, 0, 0);
        beat(0, 0, 0); beat(0, 0, 0);

        // R1: reset in the middle of a stream
        tag = "R1";
        rand_data(); beat(1, 1, 0); rand_data(); beat(1, 0, 0);
        rst = 1'b1; beat(1, 0, 0);
        rst = 1'b0; beat(0, 0, 0); beat(0, 0, 0);
        tag = "R5"; rand_data(); beat(1, 0, 0); beat(0, 0, 0); beat(0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule